// File: doc/BRIEF.md
# Read-Only Line Side Buffer

This block is a small, fully associative store of whole cache lines that sits next to the L1 data cache. Both are probed with the same memory reference in the same cycle. It holds only lines that an allocation predictor elsewhere has judged read-once: L2 fills are steered into it, and L1 never sees those lines. A load that finds its line here gets the whole line in the same cycle. No copy of any line is ever modified here.

A store never hits in this buffer. If a store names a line that the buffer holds, that copy is dropped and a misallocation pulse is raised, so the line is then fetched from L2 into L1 like any other L1 miss. Because a stored-to line only ever lives in L1, a line is never held in both structures at once. Entries are replaced in strict arrival order by a pointer that advances only when a fill is written. Fills for a line that is already held are discarded.

Top module: `ro_side_buffer`

## Requirements
- R1: After reset no entry is valid, so every load misses and no misallocation pulse appears, and the first accepted fill is written into slot 0.
- R2: A load (`lk_valid`=1, `lk_store`=0) whose line is held raises `lk_hit` in the same cycle and returns that line's data on `lk_data`.
- R3: A load whose line is not held keeps `lk_hit` low.
- R4: A reference with `lk_store`=1 never raises `lk_hit`, whether or not its line is held.
- R5: A store whose line is held raises `misalloc` in the same cycle, and that line misses on every later load until it is filled again.
- R6: A store whose line is not held leaves `misalloc` low and leaves every held line hitting.
- R7: Accepted fills are written into slots in a round-robin order. Once every slot has been filled, each further accepted fill evicts the line that arrived earliest.
- R8: The replacement pointer moves only when a fill is accepted. A slot freed by a store is not reused ahead of its turn, and the slot at the pointer is overwritten even when it is valid.
- R9: A fill for a line that is already held is discarded. The held data stays unchanged, the pointer does not move, and at most one slot ever matches a line.
- R10: A fill arriving in the same cycle as a store to the same line is discarded.
- R11: A lookup in the same cycle as a fill sees the contents from before that fill. The filled line hits from the next cycle on.
- R12: Matching uses only the line address. The low log2(LINE_BYTES) address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | A memory reference is presented this cycle |
| lk_store | input | 1 | 1 = store reference, 0 = load reference |
| lk_addr | input | ADDR_W | Byte address of the reference |
| lk_hit | output | 1 | Load found its line here (combinational) |
| lk_data | output | LINE_BYTES*8 | Line data of the hit line |
| fill_valid | input | 1 | L2 delivers a line steered to this buffer |
| fill_addr | input | ADDR_W | Byte address of the filled line |
| fill_data | input | LINE_BYTES*8 | Data of the filled line |
| misalloc | output | 1 | A store matched a held line, which is dropped this cycle |

## Verification
The bench builds the block with four slots of eight bytes and 16-bit addresses. With only four slots, the pointer wraps and the oldest entry is evicted within a few fills. Ten line addresses are used, more than the slots can hold, so loads hit and miss, stores invalidate and miss, and duplicate fills and fills racing a store to the same line all occur often. Directed cases pin down reset, wrap-around over a freed slot, and the same-cycle orderings.

// File: rtl/sb_pkg.sv
package sb_pkg;
  // Round-robin successor of a slot index.
  function automatic int unsigned sb_next_slot(int unsigned cur, int unsigned lines);
    return (cur + 1 >= lines) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/sb_fifo_ptr.sv
module sb_fifo_ptr #(
  parameter int unsigned LINES = 16,
  localparam int unsigned PTR_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr
);
  logic [PTR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (adv) ptr_d = PTR_W'(sb_pkg::sb_next_slot(32'(ptr_q), LINES));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (adv) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> ptr_q == PTR_W'(sb_pkg::sb_next_slot(32'($past(ptr_q)), LINES))); // R7
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr_q)); // R8
endmodule

// File: rtl/sb_tag_array.sv
module sb_tag_array #(
  parameter int unsigned LINES = 16,
  parameter int unsigned TAG_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] probe_tag,
  input  logic             inv_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [LINES-1:0] slot_we,
  output logic [LINES-1:0] probe_match,
  output logic [LINES-1:0] fill_match
);
  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] valid_q, valid_d;

  for (genvar i = 0; i < LINES; i++) begin : g_slot
    assign probe_match[i] = valid_q[i] && (tag_q[i] == probe_tag);
    assign fill_match[i]  = valid_q[i] && (tag_q[i] == fill_tag);

    always_comb begin
      valid_d[i] = valid_q[i];
      if (slot_we[i])                          valid_d[i] = 1'b1;
      else if (inv_en && probe_match[i])       valid_d[i] = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (slot_we[i]) tag_q[i] <= fill_tag;
    end

    AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_en && probe_match[i] && !slot_we[i]) |=> !valid_q[i]); // R5
    AST_FILL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      slot_we[i] |=> valid_q[i]); // R11
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(probe_match)); // R9
  AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_we)); // R7
endmodule

// File: rtl/sb_line_store.sv
module sb_line_store #(
  parameter int unsigned LINES  = 16,
  parameter int unsigned DATA_W = 256
) (
  input  logic              clk,
  input  logic [LINES-1:0]  slot_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LINES-1:0]  rd_sel,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] line_q [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (slot_we[i]) line_q[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < LINES; i++) begin
      if (rd_sel[i]) rdata = rdata | line_q[i];
    end
  end
endmodule

// File: rtl/ro_side_buffer.sv
module ro_side_buffer #(
  parameter int unsigned LINES      = 16,
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned ADDR_W     = 32,
  localparam int unsigned OFS_W  = $clog2(LINE_BYTES),
  localparam int unsigned TAG_W  = ADDR_W - OFS_W,
  localparam int unsigned DATA_W = LINE_BYTES * 8,
  localparam int unsigned PTR_W  = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic              lk_store,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data,
  output logic              misalloc
);
  logic [TAG_W-1:0] probe_tag, fill_tag;
  logic [LINES-1:0] probe_match, fill_match, slot_we;
  logic [PTR_W-1:0] fill_ptr;
  logic             store_ref, fill_accept, fill_present, fill_races_store;

  assign probe_tag = lk_addr[ADDR_W-1:OFS_W];
  assign fill_tag  = fill_addr[ADDR_W-1:OFS_W];
  assign store_ref = lk_valid && lk_store;

  assign fill_present     = |fill_match;
  assign fill_races_store = store_ref && (probe_tag == fill_tag);
  assign fill_accept      = fill_valid && !fill_present && !fill_races_store;

  for (genvar i = 0; i < LINES; i++) begin : g_we
    assign slot_we[i] = fill_accept && (fill_ptr == PTR_W'(i));
  end

  sb_fifo_ptr #(.LINES(LINES)) u_ptr (
    .clk (clk), .rst_n (rst_n), .adv (fill_accept), .ptr (fill_ptr)
  );

  sb_tag_array #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk (clk), .rst_n (rst_n), .probe_tag (probe_tag), .inv_en (store_ref),
    .fill_tag (fill_tag), .slot_we (slot_we),
    .probe_match (probe_match), .fill_match (fill_match)
  );

  sb_line_store #(.LINES(LINES), .DATA_W(DATA_W)) u_lines (
    .clk (clk), .slot_we (slot_we), .wdata (fill_data),
    .rd_sel (probe_match), .rdata (lk_data)
  );

  assign lk_hit   = lk_valid && !lk_store && (|probe_match);
  assign misalloc = store_ref && (|probe_match);

  AST_DUP_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_present) |=> $stable(fill_ptr)); // R9
  AST_RACE_DROPS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_races_store) |=> $stable(fill_ptr)); // R10
  AST_MISALLOC_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    misalloc |-> !lk_hit); // R4
endmodule

// File: tb/ro_side_buffer_bench.sv
module ro_side_buffer_bench;
  localparam int L  = 4;
  localparam int LB = 8;
  localparam int AW = 16;
  localparam int OW = 3;
  localparam int DW = LB * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_valid = 1'b0, lk_store = 1'b0, fill_valid = 1'b0;
  logic [AW-1:0] lk_addr = '0, fill_addr = '0;
  logic [DW-1:0] fill_data = '0;
  logic          lk_hit, misalloc;
  logic [DW-1:0] lk_data;

  always #4 clk = ~clk;

  ro_side_buffer #(.LINES(L), .LINE_BYTES(LB), .ADDR_W(AW)) u_ro_side_buffer (
    .clk (clk), .rst_n (rst_n), .lk_valid (lk_valid), .lk_store (lk_store),
    .lk_addr (lk_addr), .lk_hit (lk_hit), .lk_data (lk_data),
    .fill_valid (fill_valid), .fill_addr (fill_addr), .fill_data (fill_data),
    .misalloc (misalloc)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  bit           m_valid [L];
  int           m_tag   [L];
  logic [DW-1:0] m_data [L];
  int           m_ptr;

  function automatic int m_find(int tag);
    for (int i = 0; i < L; i++) if (m_valid[i] && m_tag[i] == tag) return i;
    return -1;
  endfunction

  function automatic logic [AW-1:0] mk(int tag, int ofs);
    return AW'((tag << OW) | (ofs & ((1 << OW) - 1)));
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(string req, bit lv, bit st, int ltag, int lofs,
                      bit fv, int ftag, logic [DW-1:0] fd);
    int  idx, fidx;
    bit  acc;
    @(negedge clk);
    lk_valid = lv; lk_store = st; lk_addr = mk(ltag, lofs);
    fill_valid = fv; fill_addr = mk(ftag, lofs + 3); fill_data = fd;
    #2;
    idx = lv ? m_find(ltag) : -1;
    chk(req, DW'(lk_hit), DW'(lv && !st && idx >= 0));
    chk(req, DW'(misalloc), DW'(lv && st && idx >= 0));
    if (lv && !st && idx >= 0) chk(req, lk_data, m_data[idx]);
    fidx = m_find(ftag);
    acc = fv && fidx < 0 && !(lv && st && ltag == ftag);
    if (lv && st && idx >= 0) m_valid[idx] = 0;
    if (acc) begin
      m_valid[m_ptr] = 1; m_tag[m_ptr] = ftag; m_data[m_ptr] = fd;
      m_ptr = (m_ptr + 1) % L;
    end
    @(posedge clk);
    #1;
    lk_valid = 0; fill_valid = 0;
  endtask

  task automatic ld(string req, int tag, int ofs);
    step(req, 1, 0, tag, ofs, 0, 0, '0);
  endtask
  task automatic st(string req, int tag);
    step(req, 1, 1, tag, 2, 0, 0, '0);
  endtask
  task automatic fl(string req, int tag, logic [DW-1:0] d);
    step(req, 0, 0, 0, 0, 1, tag, d);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    for (int i = 0; i < L; i++) begin m_valid[i] = 0; m_tag[i] = 0; m_data[i] = '0; end
    m_ptr = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    ld("R1", 1, 0);
    ld("R1", 0, 0);
    st("R1", 1);
    step("R11", 1, 0, 1, 0, 1, 1, 64'h1111_0000_aaaa_0001);  // fill to slot 0
    ld("R2", 1, 5);
    ld("R12", 1, 7);
    ld("R3", 2, 0);
    fl("R9", 1, 64'hdead_beef_dead_beef);
    ld("R9", 1, 0);
    fl("R7", 2, 64'h2222);
    fl("R7", 3, 64'h3333);
    fl("R7", 4, 64'h4444);
    st("R6", 9);
    ld("R6", 2, 1);
    st("R5", 2);
    st("R4", 2);
    ld("R5", 2, 0);
    fl("R8", 5, 64'h5555);   // lands on slot 0, evicting line 1
    ld("R8", 1, 0);
    ld("R8", 3, 0);
    fl("R7", 6, 64'h6666);
    fl("R7", 7, 64'h7777);   // evicts line 3
    ld("R7", 3, 0);
    ld("R7", 4, 0);
    step("R10", 1, 1, 8, 0, 1, 8, 64'h8888);
    ld("R10", 8, 0);
    ld("R4", 6, 0);
    step("R4", 1, 1, 6, 0, 0, 0, '0);

    for (int n = 0; n < 3000; n++) begin
      int k;
      k = int'($urandom_range(0, 9));
      case ($urandom_range(0, 3))
        0: ld("R2", k, int'($urandom_range(0, 7)));
        1: st("R5", k);
        2: fl("R7", k, {$urandom(), $urandom()});
        default: step("R11", 1, $urandom_range(0, 1) == 1, k, 1,
                      1, int'($urandom_range(0, 9)), {$urandom(), $urandom()});
      endcase
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule